// File: doc/BRIEF.md
# Predictive Autoranging Gain Controller

This block sits behind a converter that samples the output of a two-setting front-end amplifier (unity and a hundredfold gain). Every time a new signed raw sample is strobed in, the block decides which gain the amplifier should use for the samples that follow. In the unity setting it looks for small signals, where the higher gain would use the converter range better. In the high setting it guards against overrange. It extrapolates one sample ahead from the two most recent raw samples and falls back to unity as soon as the extrapolated value leaves a safe band.

Each gain setting has its own pair of signed thresholds. All four thresholds sit in registers that can be loaded at run time and that return to their defaults on reset. The decisions always use raw codes with mid-scale at zero. After any switch, the block waits until it holds two samples taken at the new gain before it may switch again. The selected gain comes out as a registered level, together with a one-cycle flag that marks each change.

Top module: `autorange_gain_ctrl`

## Requirements
- R1: After reset the gain is low (gainHigh = 0), gainChanged is 0, the sample history is invalid so the first sample never switches, and the thresholds hold their defaults: inner positive +162, inner negative -162, outer positive +32507, outer negative -32508.
- R2: In low gain, a sample strictly greater than the inner negative threshold and strictly less than the inner positive threshold switches the gain to high. A sample equal to either bound does not switch.
- R3: In high gain, the predicted next sample 2*x[n] - x[n-1] switches the gain to low when it is strictly above the outer positive threshold or strictly below the outer negative threshold. A prediction equal to either bound does not switch.
- R4: The prediction is formed at 18 bits signed and never wraps. For example, x[n-1] = +15000 and x[n] = -20000 give -55000, which switches to low.
- R5: In high gain the current sample alone never causes a switch. A sample above the outer positive threshold leaves the gain high when its prediction is within the band.
- R6: After any gain change, the next valid sample only refills the history and cannot switch. A switch is possible again from the second sample taken at the new gain onward.
- R7: gainHigh and gainChanged change only in the clock cycle after a cycle with sampleValid = 1. gainChanged is high for exactly that one cycle when gainHigh toggles.
- R8: A write with thrWe = 1 loads thrData into the threshold chosen by thrSel (0 inner positive, 1 inner negative, 2 outer positive, 3 outer negative). A sample strobed in the same cycle is still judged against the old value.
- R9: In high gain the inner thresholds are not consulted, so a sample inside the inner band leaves the gain high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Strobe marking a new raw sample |
| sampleData | input | 16 | Signed raw sample, mid-scale zero |
| thrWe | input | 1 | Threshold register write enable |
| thrSel | input | 2 | Threshold select: 0 inner pos, 1 inner neg, 2 outer pos, 3 outer neg |
| thrData | input | 16 | Signed value to load into the selected threshold |
| gainHigh | output | 1 | Gain select: 1 = hundredfold, 0 = unity |
| gainChanged | output | 1 | One-cycle pulse when gainHigh toggles |

## Verification
A threshold load and a sample decision can fall in the same clock cycle. The bench provokes this by lowering the outer positive threshold in the very cycle that a high-gain sample arrives whose prediction lies between the new and the old value. It then expects no switch on that sample and a switch on the next sample, whose prediction also lies above only the new value. A second collision is between a switch and the following strobe: a sample that would trip the opposite threshold arrives right after a change, and the bench expects the gain to stay put.

// File: rtl/agc_pkg.sv
package agc_pkg;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic captureSample;
  } agcStrobes_t;

  // comparison results from the datapath to the control
  typedef struct packed {
    logic inWindow;
    logic overPred;
  } agcFlags_t;

endpackage

// File: rtl/agc_datapath.sv
module agc_datapath
  import agc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_THR = 4,
  parameter logic signed [DATA_W-1:0] INNER_POS = 16'sd162,
  parameter logic signed [DATA_W-1:0] INNER_NEG = -16'sd162,
  parameter logic signed [DATA_W-1:0] OUTER_POS = 16'sd32507,
  parameter logic signed [DATA_W-1:0] OUTER_NEG = -16'sd32508
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  agcStrobes_t                strobes,
  input  logic signed [DATA_W-1:0]   sampleData,
  input  logic                       thrWe,
  input  logic [$clog2(NUM_THR)-1:0] thrSel,
  input  logic signed [DATA_W-1:0]   thrData,
  output agcFlags_t                  flags
);

  localparam int PRED_W = DATA_W + 2;
  localparam int SEL_INNER_POS = 0;
  localparam int SEL_INNER_NEG = 1;
  localparam int SEL_OUTER_POS = 2;
  localparam int SEL_OUTER_NEG = 3;
  localparam logic signed [DATA_W-1:0] THR_INIT [NUM_THR] =
    '{INNER_POS, INNER_NEG, OUTER_POS, OUTER_NEG};

  logic signed [DATA_W-1:0] thrReg [NUM_THR];
  logic signed [DATA_W-1:0] prevSample;
  logic signed [PRED_W-1:0] curExt, prevExt, predicted;
  logic signed [PRED_W-1:0] outPosExt, outNegExt;

  // threshold registers, one per slot
  for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        thrReg[i] <= THR_INIT[i];
      end else if (thrWe && (int'(thrSel) == i)) begin
        thrReg[i] <= thrData;
      end
    end
  end

  // one-deep sample history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSample <= '0;
    end else if (strobes.captureSample) begin
      prevSample <= sampleData;
    end
  end

  // first-order extrapolation with two guard bits
  always_comb begin
    curExt    = {{2{sampleData[DATA_W-1]}}, sampleData};
    prevExt   = {{2{prevSample[DATA_W-1]}}, prevSample};
    predicted = (curExt <<< 1) - prevExt;
    outPosExt = {{2{thrReg[SEL_OUTER_POS][DATA_W-1]}}, thrReg[SEL_OUTER_POS]};
    outNegExt = {{2{thrReg[SEL_OUTER_NEG][DATA_W-1]}}, thrReg[SEL_OUTER_NEG]};
  end

  always_comb begin
    flags.inWindow = (sampleData > thrReg[SEL_INNER_NEG]) &&
                     (sampleData < thrReg[SEL_INNER_POS]);
    flags.overPred = (predicted > outPosExt) || (predicted < outNegExt);
  end

  // R4: the extrapolation must agree in sign with 2*x[n]-x[n-1] at full precision
  assert_pred_sign_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sampleData[DATA_W-1] && !prevSample[DATA_W-1]) |-> predicted[PRED_W-1]);

endmodule

// File: rtl/agc_control.sv
module agc_control
  import agc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  agcFlags_t   flags,
  output agcStrobes_t strobes,
  output logic        gainHigh,
  output logic        gainChanged
);

  logic histValid;
  logic switchNow;

  always_comb begin
    strobes.captureSample = sampleValid;
    switchNow = sampleValid && histValid &&
                (gainHigh ? flags.overPred : flags.inWindow);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainHigh    <= 1'b0;
      gainChanged <= 1'b0;
      histValid   <= 1'b0;
    end else begin
      gainChanged <= switchNow;
      if (switchNow) begin
        gainHigh <= ~gainHigh;
      end
      if (sampleValid) begin
        histValid <= ~switchNow;
      end
    end
  end

  // R7: flag marks exactly the cycles in which the gain toggled
  assert_flag_matches_toggle_R7: assert property (@(posedge clk) disable iff (!rstN)
    gainChanged == (gainHigh != $past(gainHigh)));

  // R7: a change always follows a sample strobe
  assert_change_after_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    gainChanged |-> $past(sampleValid));

  // R6: no two changes back to back
  assert_no_double_switch_R6: assert property (@(posedge clk) disable iff (!rstN)
    gainChanged |=> !gainChanged);

  // R2: raising the gain needs a sample inside the inner band
  assert_rise_in_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gainHigh) |-> $past(flags.inWindow));

  // R3: dropping the gain needs an out-of-band prediction
  assert_fall_on_prediction_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gainHigh) |-> $past(flags.overPred));

endmodule

// File: rtl/autorange_gain_ctrl.sv
module autorange_gain_ctrl
  import agc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_THR = 4,
  parameter logic signed [DATA_W-1:0] INNER_POS = 16'sd162,
  parameter logic signed [DATA_W-1:0] INNER_NEG = -16'sd162,
  parameter logic signed [DATA_W-1:0] OUTER_POS = 16'sd32507,
  parameter logic signed [DATA_W-1:0] OUTER_NEG = -16'sd32508
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic signed [DATA_W-1:0]   sampleData,
  input  logic                       thrWe,
  input  logic [$clog2(NUM_THR)-1:0] thrSel,
  input  logic signed [DATA_W-1:0]   thrData,
  output logic                       gainHigh,
  output logic                       gainChanged
);

  agcStrobes_t strobes;
  agcFlags_t   flags;

  agc_datapath #(
    .DATA_W(DATA_W), .NUM_THR(NUM_THR),
    .INNER_POS(INNER_POS), .INNER_NEG(INNER_NEG),
    .OUTER_POS(OUTER_POS), .OUTER_NEG(OUTER_NEG)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sampleData(sampleData),
    .thrWe(thrWe), .thrSel(thrSel), .thrData(thrData), .flags(flags)
  );

  agc_control control_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .flags(flags),
    .strobes(strobes), .gainHigh(gainHigh), .gainChanged(gainChanged)
  );

endmodule

// File: tb/autorange_gain_ctrl_tb_top.sv
`timescale 1ns/1ps
module autorange_gain_ctrl_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [15:0] sampleData = '0;
  logic thrWe = 1'b0;
  logic [1:0] thrSel = '0;
  logic signed [15:0] thrData = '0;
  logic gainHigh, gainChanged;

  int checkCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  autorange_gain_ctrl dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .thrWe(thrWe), .thrSel(thrSel), .thrData(thrData),
    .gainHigh(gainHigh), .gainChanged(gainChanged)
  );

  // {requirement, sample, expected gainHigh, expected gainChanged}
  localparam int NVEC = 26;
  localparam logic [21:0] VEC [NVEC] = '{
    {4'd1,  16'sd50,     1'b0, 1'b0},  // R1 first sample cannot switch
    {4'd2,  16'sd50,     1'b1, 1'b1},  // R2 inside inner band
    {4'd6,  16'sd30000,  1'b1, 1'b0},  // R6 blocked after change
    {4'd3,  16'sd30000,  1'b1, 1'b0},  // R3 prediction 30000 in band
    {4'd3,  16'sd32600,  1'b0, 1'b1},  // R3 prediction 35200 above
    {4'd6,  16'sd100,    1'b0, 1'b0},  // R6 blocked
    {4'd2,  16'sd162,    1'b0, 1'b0},  // R2 equal to inner positive
    {4'd2,  -16'sd162,   1'b0, 1'b0},  // R2 equal to inner negative
    {4'd2,  -16'sd161,   1'b1, 1'b1},  // R2 just inside
    {4'd6,  16'sd0,      1'b1, 1'b0},  // R6 blocked
    {4'd9,  16'sd0,      1'b1, 1'b0},  // R9 inner band ignored in high gain
    {4'd3,  16'sd16253,  1'b1, 1'b0},  // R3 prediction 32506
    {4'd3,  16'sd24380,  1'b1, 1'b0},  // R3 prediction 32507 equal
    {4'd3,  16'sd28444,  1'b0, 1'b1},  // R3 prediction 32508
    {4'd6,  16'sd0,      1'b0, 1'b0},  // R6 blocked
    {4'd2,  16'sd0,      1'b1, 1'b1},  // R2 switch up
    {4'd6,  16'sd32600,  1'b1, 1'b0},  // R6 blocked though large
    {4'd5,  16'sd32550,  1'b1, 1'b0},  // R5 sample above band, prediction 32500
    {4'd5,  16'sd20000,  1'b1, 1'b0},  // R5 prediction 7450
    {4'd5,  16'sd15000,  1'b1, 1'b0},  // R5 prediction 10000
    {4'd4,  -16'sd20000, 1'b0, 1'b1},  // R4 prediction -55000, wrapped value would be positive
    {4'd6,  16'sd0,      1'b0, 1'b0},  // R6 blocked
    {4'd2,  16'sd0,      1'b1, 1'b1},  // R2 switch up
    {4'd6,  16'sd0,      1'b1, 1'b0},  // R6 blocked
    {4'd3,  -16'sd16254, 1'b1, 1'b0},  // R3 prediction -32508 equal
    {4'd3,  -16'sd24382, 1'b0, 1'b1}   // R3 prediction -32510
  };

  task automatic check(input int req, input logic expG, input logic expC, input string what);
    checkCount++;
    if (gainHigh !== expG || gainChanged !== expC) begin
      failCount++;
      $display("FAIL R%0d %s: gainHigh=%0b gainChanged=%0b expected gainHigh=%0b gainChanged=%0b",
               req, what, gainHigh, gainChanged, expG, expC);
    end
  endtask

  // drive one strobed sample, optionally with a threshold write, and sample outputs one cycle later
  task automatic sendSample(input logic signed [15:0] d, input logic wr,
                            input logic [1:0] sel, input logic signed [15:0] val);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleData  = d;
    thrWe       = wr;
    thrSel      = sel;
    thrData     = val;
    @(negedge clk);
    sampleValid = 1'b0;
    thrWe       = 1'b0;
  endtask

  task automatic writeThr(input logic [1:0] sel, input logic signed [15:0] val);
    @(negedge clk);
    thrWe   = 1'b1;
    thrSel  = sel;
    thrData = val;
    @(negedge clk);
    thrWe   = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, 1'b0, 1'b0, "state during reset");  // R1
    rstN = 1'b1;
    @(negedge clk);
    check(1, 1'b0, 1'b0, "state after reset");   // R1

    for (int i = 0; i < NVEC; i++) begin
      sendSample(VEC[i][17:2], 1'b0, 2'd0, 16'sd0);
      check(int'(VEC[i][21:18]), VEC[i][1], VEC[i][0], $sformatf("table row %0d", i));
    end

    // R7: no strobe, data inside inner band: nothing moves and the flag has dropped
    sampleData = 16'sd0;
    repeat (3) @(negedge clk);
    check(7, 1'b0, 1'b0, "idle with in-band data");

    // R8: widen the inner band and see it used
    sendSample(16'sd500, 1'b0, 2'd0, 16'sd0);
    check(8, 1'b0, 1'b0, "refill before load");
    writeThr(2'd0, 16'sd1000);
    writeThr(2'd1, -16'sd1000);
    sendSample(16'sd500, 1'b0, 2'd0, 16'sd0);
    check(8, 1'b1, 1'b1, "switch on widened inner band");
    sendSample(16'sd0, 1'b0, 2'd0, 16'sd0);
    check(6, 1'b1, 1'b0, "blocked after change");
    sendSample(16'sd0, 1'b0, 2'd0, 16'sd0);
    check(9, 1'b1, 1'b0, "high gain holds near zero");
    // R8: load outer positive = 100 in the same cycle as a sample predicting 400
    sendSample(16'sd200, 1'b1, 2'd2, 16'sd100);
    check(8, 1'b1, 1'b0, "same-cycle load uses old threshold");
    sendSample(16'sd200, 1'b0, 2'd0, 16'sd0);
    check(8, 1'b0, 1'b1, "next sample uses new threshold");

    // R1: reset restores default thresholds and invalidates history
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(1, 1'b0, 1'b0, "mid-run reset");
    rstN = 1'b1;
    sendSample(16'sd500, 1'b0, 2'd0, 16'sd0);
    check(1, 1'b0, 1'b0, "first sample after reset");
    sendSample(16'sd500, 1'b0, 2'd0, 16'sd0);
    check(1, 1'b0, 1'b0, "default inner band restored");
    sendSample(16'sd50, 1'b0, 2'd0, 16'sd0);
    check(1, 1'b1, 1'b1, "default inner band switches");
    @(negedge clk);
    check(7, 1'b1, 1'b0, "flag lasts one cycle");

    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finishRun();
    end
  end

endmodule